// File: doc/BRIEF.md
# Interrupt Accept and Return Controller

This block sequences interrupts for a small microcontroller core. Each clock cycle in which the core finishes an instruction, the core raises `step` and reports the instruction's class on `cls` and its address on `cur_pc`. The block decides at that boundary whether a pending request is taken. Requests come from one maskable source, whose vector is already chosen by external priority logic, and from a non-maskable watchdog source. When a request is taken, the block saves the return address on an internal call stack, clears the master enable flag and redirects the program counter to the vector.

Instructions that change control flow or the enable flag hold off acceptance. While such instructions follow one another, a pending request keeps waiting. It is taken when the first ordinary instruction completes.

Two return instructions pop the stack and reload the program counter with the saved address plus one. The normal return always sets the enable flag. The watchdog return puts back the flag value that was saved when the watchdog interrupt was entered. Leaving a watchdog interrupt through the normal return therefore leaves interrupts enabled, even if they were disabled before. The stack depth is a parameter. Pushes and pops wrap silently around the depth.

Top module: `intr_seq_ctrl`

## Requirements
- R1: After reset is released, the enable flag (`mie_o`) is 0, the stack pointer (`sp_o`) is 0, and `ack_irq`, `ack_nmi` and `pc_ld` are 0 while `step` is 0.
- R2: In a cycle with `step`=1, `cls`=0 (ordinary instruction) and `nmi_req`=1, the watchdog request is taken whatever the enable flag is. In that same cycle `ack_nmi`=1, `pc_ld`=1 and `pc_val` equals the `NMI_VEC` parameter. At most one of `ack_nmi` and `ack_irq` is 1 in any cycle.
- R3: In a cycle with `step`=1, `cls`=0, `nmi_req`=0, `irq_req`=1 and the enable flag at 1, the maskable request is taken. In that same cycle `ack_irq`=1, `pc_ld`=1 and `pc_val`=`irq_vec`. While the flag is 0, `ack_irq` stays 0.
- R4: No request is taken in a cycle with `step`=0. No request is taken when the completing instruction has any class other than 0: 1 hold-type, 2 normal return, 3 watchdog return, 4 enable, 5 disable, 6 and 7 treated as hold-type. A request that is held through any run of such instructions is taken when the next class-0 instruction completes.
- R5: On taking a request, the block writes `cur_pc` at the stack pointer and increments the pointer. From the next cycle the enable flag is 0. A watchdog entry also saves the previous flag value.
- R6: Class 2 with `step`=1 decrements the stack pointer. In the same cycle it drives `pc_ld`=1 and `pc_val` = (entry at the decremented pointer) + 1, modulo 2^`PC_W`. From the next cycle the flag is 1.
- R7: Class 3 with `step`=1 pops and reloads like R6. It sets the enable flag to the value saved at the most recent watchdog entry.
- R8: A watchdog interrupt taken while the flag is 0 and left with class 2 leaves the flag at 1.
- R9: Class 4 sets the enable flag and class 5 clears it, visible from the cycle after `step`.
- R10: The stack pointer counts modulo `DEPTH`. A push at `DEPTH`-1 goes to 0 and overwrites entry 0. A pop at 0 goes to `DEPTH`-1. No error is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step | input | 1 | An instruction completes this cycle |
| cls | input | 3 | Class of the completing instruction (codes in R4) |
| cur_pc | input | PC_W | Address of the completing instruction |
| irq_req | input | 1 | Maskable request pending |
| irq_vec | input | PC_W | Vector of the maskable request |
| nmi_req | input | 1 | Watchdog request pending |
| ack_irq | output | 1 | Maskable request taken this cycle |
| ack_nmi | output | 1 | Watchdog request taken this cycle |
| pc_ld | output | 1 | Program counter reload this cycle |
| pc_val | output | PC_W | Reload value, valid while `pc_ld` is 1 |
| mie_o | output | 1 | Master interrupt enable flag |
| sp_o | output | SP_W | Call stack pointer |

## Verification
The bench builds the block with `DEPTH`=4, `PC_W`=8 and `NMI_VEC`=8'h04. With a four-entry stack, a handful of entries reach wrap-around in both directions, and every slot is written before the first pop. The main sweep goes over all eight class codes, both flag values, both request inputs and both `step` levels. Before each point, an enable or disable step sets the flag. An arithmetic model in the bench tracks the flag, the saved bit, the pointer and the stack contents. Directed runs cover chains of hold-type instructions and the crossed return cases.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  typedef enum logic [2:0] {
    IC_PLAIN = 3'd0,
    IC_HOLD  = 3'd1,
    IC_RTI   = 3'd2,
    IC_RTNMI = 3'd3,
    IC_EI    = 3'd4,
    IC_DI    = 3'd5,
    IC_RSV6  = 3'd6,
    IC_RSV7  = 3'd7
  } icls_e;

  function automatic logic is_return(icls_e c);
    return (c == IC_RTI) || (c == IC_RTNMI);
  endfunction

endpackage

// File: rtl/intr_accept.sv
module intr_accept
  import intr_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  icls_e cls,
  input  logic  mie,
  input  logic  irq_req,
  input  logic  nmi_req,
  output logic  take_irq,
  output logic  take_nmi
);

  logic boundary_ok;

  always_comb begin
    boundary_ok = step && (cls == IC_PLAIN);
    take_nmi    = boundary_ok && nmi_req;
    take_irq    = boundary_ok && !nmi_req && irq_req && mie;
  end

  p_one_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_irq && take_nmi));

  p_nmi_unmasked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cls == IC_PLAIN && nmi_req && !mie) |-> take_nmi);

  p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> mie);

  p_hold_defer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step || cls != IC_PLAIN) |-> !(take_irq || take_nmi));

endmodule

// File: rtl/intr_mie_ctl.sv
module intr_mie_ctl
  import intr_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  icls_e cls,
  input  logic  take_irq,
  input  logic  take_nmi,
  output logic  mie
);

  logic mie_q, mie_d;
  logic sav_q, sav_d;
  logic upd_en;

  always_comb begin
    mie_d  = mie_q;
    sav_d  = sav_q;
    upd_en = step || take_irq || take_nmi;
    if (take_nmi) begin
      sav_d = mie_q;
      mie_d = 1'b0;
    end else if (take_irq) begin
      mie_d = 1'b0;
    end else if (step) begin
      case (cls)
        IC_RTI:   mie_d = 1'b1;
        IC_RTNMI: mie_d = sav_q;
        IC_EI:    mie_d = 1'b1;
        IC_DI:    mie_d = 1'b0;
        default:  mie_d = mie_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mie_q <= 1'b0;
      sav_q <= 1'b0;
    end else if (upd_en) begin
      mie_q <= mie_d;
      sav_q <= sav_d;
    end
  end

  assign mie = mie_q;

  p_entry_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq || take_nmi) |=> !mie_q);

  p_rti_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cls == IC_RTI) |=> mie_q);

  p_ei_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cls == IC_EI) |=> mie_q);

  p_di_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cls == IC_DI) |=> !mie_q);

  p_hold_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cls == IC_HOLD) |=> $stable(mie_q));

endmodule

// File: rtl/intr_ret_stack.sv
module intr_ret_stack #(
  parameter int PC_W  = 12,
  parameter int DEPTH = 8,
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] push_data,
  output logic [PC_W-1:0] pop_data,
  output logic [SP_W-1:0] sp
);

  localparam logic [SP_W-1:0] SP_LAST = SP_W'(DEPTH - 1);

  logic [SP_W-1:0] sp_q, sp_d, sp_inc, sp_dec;
  logic [PC_W-1:0] rd_arr [DEPTH];

  always_comb begin
    sp_inc = (sp_q == SP_LAST) ? '0 : sp_q + 1'b1;
    sp_dec = (sp_q == '0) ? SP_LAST : sp_q - 1'b1;
    sp_d   = sp_q;
    if (push)     sp_d = sp_inc;
    else if (pop) sp_d = sp_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           sp_q <= '0;
    else if (push || pop) sp_q <= sp_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gen_ent
    logic [PC_W-1:0] q;
    logic            wr_en;
    assign wr_en = push && (sp_q == SP_W'(g));
    always_ff @(posedge clk) begin
      if (wr_en) q <= push_data;
    end
    assign rd_arr[g] = q;
  end

  assign pop_data = rd_arr[sp_dec];
  assign sp       = sp_q;

  p_no_push_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

  p_wrap_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && sp_q == SP_LAST) |=> (sp_q == '0));

  p_wrap_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && sp_q == '0) |=> (sp_q == SP_LAST));

  p_push_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && sp_q != SP_LAST) |=> (sp_q == $past(sp_q) + 1'b1));

  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && sp_q != '0) |=> (sp_q + 1'b1 == $past(sp_q)));

endmodule

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
#(
  parameter int              PC_W    = 12,
  parameter int              DEPTH   = 8,
  parameter logic [PC_W-1:0] NMI_VEC = PC_W'(4),
  localparam int             SP_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic [2:0]      cls,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            irq_req,
  input  logic [PC_W-1:0] irq_vec,
  input  logic            nmi_req,
  output logic            ack_irq,
  output logic            ack_nmi,
  output logic            pc_ld,
  output logic [PC_W-1:0] pc_val,
  output logic            mie_o,
  output logic [SP_W-1:0] sp_o
);

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  icls_e           cls_v;
  logic            take_irq, take_nmi;
  logic            mie;
  logic            do_pop;
  logic [PC_W-1:0] pop_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cls_v  = icls_e'(cls);
  assign do_pop = step && is_return(cls_v);

  intr_accept u_accept (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step     (step),
    .cls      (cls_v),
    .mie      (mie),
    .irq_req  (irq_req),
    .nmi_req  (nmi_req),
    .take_irq (take_irq),
    .take_nmi (take_nmi)
  );

  intr_mie_ctl u_mie (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step     (step),
    .cls      (cls_v),
    .take_irq (take_irq),
    .take_nmi (take_nmi),
    .mie      (mie)
  );

  intr_ret_stack #(
    .PC_W  (PC_W),
    .DEPTH (DEPTH)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (take_irq || take_nmi),
    .pop       (do_pop),
    .push_data (cur_pc),
    .pop_data  (pop_data),
    .sp        (sp_o)
  );

  always_comb begin
    pc_ld  = 1'b0;
    pc_val = '0;
    if (take_nmi) begin
      pc_ld  = 1'b1;
      pc_val = NMI_VEC;
    end else if (take_irq) begin
      pc_ld  = 1'b1;
      pc_val = irq_vec;
    end else if (do_pop) begin
      pc_ld  = 1'b1;
      pc_val = pop_data + 1'b1;
    end
  end

  assign ack_irq = take_irq;
  assign ack_nmi = take_nmi;
  assign mie_o   = mie;

  p_ret_reload_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    do_pop |-> pc_ld);

  p_ld_cause_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    pc_ld |-> step);

endmodule

// File: tb/test_intr_seq_ctrl.sv
`timescale 1ns/1ps
module test_intr_seq_ctrl;

  localparam int         PW = 8;
  localparam int         D  = 4;
  localparam int         SW = 2;
  localparam logic [7:0] NV = 8'h04;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          step;
  logic [2:0]    cls;
  logic [PW-1:0] cur_pc, irq_vec, pc_val;
  logic          irq_req, nmi_req, ack_irq, ack_nmi, pc_ld, mie_o;
  logic [SW-1:0] sp_o;

  always #4 clk = ~clk;

  intr_seq_ctrl #(.PC_W(PW), .DEPTH(D), .NMI_VEC(NV)) i_intr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .step(step), .cls(cls), .cur_pc(cur_pc),
    .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req),
    .ack_irq(ack_irq), .ack_nmi(ack_nmi), .pc_ld(pc_ld), .pc_val(pc_val),
    .mie_o(mie_o), .sp_o(sp_o)
  );

  int         total = 0;
  int         bad   = 0;
  bit         done  = 1'b0;
  bit         m_mie, m_sav;
  int         m_sp;
  logic [7:0] m_stk [D];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_step(bit st, int c, logic [7:0] pc, bit irq, logic [7:0] vec, bit nmi);
    bit         e_nmi, e_irq, e_ret, e_ld;
    logic [7:0] e_pc;
    string      tg;
    @(negedge clk);
    step = st; cls = 3'(c); cur_pc = pc; irq_req = irq; irq_vec = vec; nmi_req = nmi;
    #1;
    e_nmi = st && c == 0 && nmi;
    e_irq = st && c == 0 && !nmi && irq && m_mie;
    e_ret = st && (c == 2 || c == 3);
    e_ld  = e_nmi || e_irq || e_ret;
    e_pc  = e_nmi ? NV : e_irq ? vec : e_ret ? 8'(m_stk[(m_sp + D - 1) % D] + 1) : 8'h00;
    tg = (!st || c != 0) ? "R4" : "R2";
    chk(tg, "ack_nmi", 32'(ack_nmi), 32'(e_nmi));
    tg = (!st || c != 0) ? "R4" : "R3";
    chk(tg, "ack_irq", 32'(ack_irq), 32'(e_irq));
    tg = e_ret ? "R6" : "R4";
    chk(tg, "pc_ld", 32'(pc_ld), 32'(e_ld));
    if (e_ld) begin
      tg = e_nmi ? "R2" : e_irq ? "R3" : (c == 3) ? "R7" : "R6";
      chk(tg, "pc_val", 32'(pc_val), 32'(e_pc));
    end
    @(posedge clk);
    if (e_nmi || e_irq) begin
      m_stk[m_sp] = pc;
      m_sp = (m_sp + 1) % D;
      if (e_nmi) m_sav = m_mie;
      m_mie = 1'b0;
      tg = "R5";
    end else if (e_ret) begin
      m_sp  = (m_sp + D - 1) % D;
      m_mie = (c == 2) ? 1'b1 : m_sav;
      tg = (c == 2) ? "R6" : "R7";
    end else if (st && (c == 4 || c == 5)) begin
      m_mie = (c == 4);
      tg = "R9";
    end else begin
      tg = "R4";
    end
    #1;
    chk(tg, "mie_o", 32'(mie_o), 32'(m_mie));
    chk("R10", "sp_o", 32'(sp_o), 32'(m_sp));
  endtask

  initial begin
    rst_n = 1'b0; step = 1'b0; cls = 3'd0; cur_pc = '0;
    irq_req = 1'b0; irq_vec = '0; nmi_req = 1'b0;
    m_mie = 1'b0; m_sav = 1'b0; m_sp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "mie_o", 32'(mie_o), 32'd0);
    chk("R1", "sp_o", 32'(sp_o), 32'd0);
    chk("R1", "ack_irq", 32'(ack_irq), 32'd0);
    chk("R1", "ack_nmi", 32'(ack_nmi), 32'd0);
    chk("R1", "pc_ld", 32'(pc_ld), 32'd0);

    // R10: five watchdog entries on a four-deep stack wrap and overwrite slot 0
    for (int i = 0; i <= D; i++) do_step(1, 0, 8'(8'h10 + i), 0, 8'h00, 1);
    chk("R10", "sp after wrap", 32'(sp_o), 32'd1);
    // R10: pops wrap back from 0 to D-1; the first pop returns 0x14 + 1
    do_step(1, 2, 8'h00, 0, 8'h00, 0);
    do_step(1, 2, 8'h00, 0, 8'h00, 0);
    chk("R10", "sp after underflow", 32'(sp_o), 32'(D - 1));

    // R4: a request held through a chain of hold-type instructions
    do_step(1, 4, 8'h20, 0, 8'h00, 0);
    for (int k = 0; k < 6; k++) do_step(1, (k % 2 == 0) ? 1 : 6 + k % 2, 8'h21, 1, 8'h55, 0);
    do_step(0, 0, 8'h22, 1, 8'h55, 0);
    do_step(1, 0, 8'h23, 1, 8'h55, 0);
    chk("R4", "ack after chain", 32'(mie_o), 32'd0);

    // R8: watchdog taken with flag 0, left by normal return
    do_step(1, 5, 8'h30, 0, 8'h00, 0);
    do_step(1, 0, 8'h31, 0, 8'h00, 1);
    do_step(1, 2, 8'h00, 0, 8'h00, 0);
    chk("R8", "mie after normal return", 32'(mie_o), 32'd1);

    // R7: watchdog return restores 1 and 0
    do_step(1, 0, 8'h40, 0, 8'h00, 1);
    do_step(1, 3, 8'h00, 0, 8'h00, 0);
    chk("R7", "restored 1", 32'(mie_o), 32'd1);
    do_step(1, 5, 8'h41, 0, 8'h00, 0);
    do_step(1, 0, 8'h42, 0, 8'h00, 1);
    do_step(1, 4, 8'h43, 0, 8'h00, 0);
    do_step(1, 3, 8'h00, 0, 8'h00, 0);
    chk("R7", "restored 0", 32'(mie_o), 32'd0);

    // Exhaustive sweep: class x flag x irq x nmi x step
    for (int c = 0; c < 8; c++)
      for (int mi = 0; mi < 2; mi++)
        for (int ir = 0; ir < 2; ir++)
          for (int nm = 0; nm < 2; nm++)
            for (int st = 0; st < 2; st++) begin
              do_step(1, (mi != 0) ? 4 : 5, 8'h00, 0, 8'h00, 0);
              do_step(st != 0, c, 8'(c * 16 + mi * 8 + ir * 4 + nm * 2 + st),
                      ir != 0, 8'(8'h80 + c * 8 + ir * 4 + nm), nm != 0);
            end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule